// File: doc/BRIEF.md
# Two-Level Lookahead Adder-Subtractor

This block adds or subtracts two unsigned operands. By default the operands are 16 bits wide, split into four 4-bit groups. Each bit forms a propagate term (the XOR of its two operand bits) and a generate term (their AND). Inside each group, every carry is written as one flat sum of products of those terms and the group's carry-in. No carry waits for the carry below it. Each group also reports a group propagate and a group generate. A second lookahead level uses these pairs and the initial carry to form every group carry-in, and the final carry-out, at the same time.

Subtraction inverts every bit of B and forces the initial carry to one. An optional register stage sits right after the group propagate/generate signals. With that stage, results come out one cycle after issue, in issue order, and a new operation can start every cycle. A valid bit travels with the data.

In add mode, if either operand is zero, the propagate and generate terms are forced to zero. The lookahead network then stays idle, and the non-zero operand is passed through as the result.

Top module: `lookahead_addsub`

## Requirements
- R1: In add mode (`sub`=0), `result` equals (A + B) mod 2^W, where W = GRP_W*NGRP.
- R2: In subtract mode (`sub`=1), `result` equals (A + ~B + 1) mod 2^W. `carry_out` is 1 exactly when A >= B, read as unsigned numbers.
- R3: In add mode, `carry_out` equals bit W of the (W+1)-bit sum A + B.
- R4: Group k covers bits k*GRP_W to k*GRP_W+GRP_W-1, and the effective B is ~B in subtract mode and B otherwise. `grp_p[k]` is 1 when A and the effective B differ in every bit of group k. `grp_g[k]` is 1 when that group's two slices, added with no carry-in, carry out of the group.
- R5: For no group are `grp_p[k]` and `grp_g[k]` both 1 at the same time.
- R6: In add mode with A=0 or B=0, `grp_p` and `grp_g` are all zero, `carry_out` is 0, and `result` is the other operand. In subtract mode a zero operand does not gate anything, and the taps follow R4.
- R7: With PIPE=1, the outputs for an operation appear one cycle after its issue cycle, and a new operation can be issued every cycle. `out_valid` is the `in_valid` of the previous cycle.
- R8: While `rst_n` is low, and after reset until the first valid operation completes, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks an operation issued this cycle |
| a | input | W | Operand A |
| b | input | W | Operand B |
| sub | input | 1 | 1 selects A-B, 0 selects A+B |
| out_valid | output | 1 | Marks a valid result |
| result | output | W | Sum or difference |
| carry_out | output | 1 | Carry out of the top group (1 means no borrow in subtract mode) |
| grp_p | output | NGRP | Group propagate debug taps |
| grp_g | output | NGRP | Group generate debug taps |

## Verification
The checker runs on every cycle. It checks that the result and the carry-out match a plain arithmetic sum or difference of the operands issued one cycle earlier, and that the borrow sense of the subtract carry is right. It also checks that the group taps never show propagate and generate together, that the taps go dark under zero-operand gating, and that the valid bit follows issue one cycle later. The per-group tap values, and the fact that gating is skipped in subtract mode, are shown only by the bench. The bench sweeps every operand pair of an 8-bit, two-group build in both modes and inserts idle bubbles between operations.

// File: rtl/lookahead_addsub.sv
module lookahead_addsub #(
  parameter int GRP_W = 4,
  parameter int NGRP  = 4,
  parameter bit PIPE  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [GRP_W*NGRP-1:0]  a,
  input  logic [GRP_W*NGRP-1:0]  b,
  input  logic                   sub,
  output logic                   out_valid,
  output logic [GRP_W*NGRP-1:0]  result,
  output logic                   carry_out,
  output logic [NGRP-1:0]        grp_p,
  output logic [NGRP-1:0]        grp_g
);
  localparam int W = GRP_W * NGRP;

  function automatic logic carry_at(input logic [W-1:0] p, input logic [W-1:0] g,
                                    input logic cin, input int n);
    logic r, t;
    r = 1'b0;
    for (int j = 0; j < W; j++) begin
      if (j < n) begin
        t = g[j];
        for (int m = 0; m < W; m++)
          if (m > j && m < n) t = t & p[m];
        r = r | t;
      end
    end
    t = cin;
    for (int m = 0; m < W; m++)
      if (m < n) t = t & p[m];
    return r | t;
  endfunction

  logic [W-1:0] b_eff, c_p, c_g, c_pass;
  logic         c_idle;
  logic [NGRP-1:0] c_gp, c_gg;

  assign b_eff  = sub ? ~b : b;
  assign c_idle = !sub && (a == '0 || b == '0);
  assign c_p    = c_idle ? '0 : (a ^ b_eff);
  assign c_g    = c_idle ? '0 : (a & b_eff);
  assign c_pass = a | b;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp1
    logic [W-1:0] pk, gk;
    assign pk = {{(W-GRP_W){1'b0}}, c_p[k*GRP_W +: GRP_W]};
    assign gk = {{(W-GRP_W){1'b0}}, c_g[k*GRP_W +: GRP_W]};
    assign c_gp[k] = &c_p[k*GRP_W +: GRP_W];
    assign c_gg[k] = carry_at(pk, gk, 1'b0, GRP_W);
  end

  logic            s_v, s_c0, s_idle;
  logic [W-1:0]    s_p, s_g, s_pass;
  logic [NGRP-1:0] s_gp, s_gg;

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_v    <= 1'b0;
        s_c0   <= 1'b0;
        s_idle <= 1'b0;
        s_p    <= '0;
        s_g    <= '0;
        s_pass <= '0;
        s_gp   <= '0;
        s_gg   <= '0;
      end else begin
        s_v    <= in_valid;
        s_c0   <= sub;
        s_idle <= c_idle;
        s_p    <= c_p;
        s_g    <= c_g;
        s_pass <= c_pass;
        s_gp   <= c_gp;
        s_gg   <= c_gg;
      end
    end
  end else begin : g_comb
    assign s_v    = in_valid;
    assign s_c0   = sub;
    assign s_idle = c_idle;
    assign s_p    = c_p;
    assign s_g    = c_g;
    assign s_pass = c_pass;
    assign s_gp   = c_gp;
    assign s_gg   = c_gg;
  end

  logic [W-1:0]  gp_w, gg_w, sum_w;
  logic [NGRP:0] blk_c;

  assign gp_w = {{(W-NGRP){1'b0}}, s_gp};
  assign gg_w = {{(W-NGRP){1'b0}}, s_gg};

  for (genvar k = 0; k <= NGRP; k++) begin : g_lvl2
    assign blk_c[k] = carry_at(gp_w, gg_w, s_c0, k);
  end

  for (genvar k = 0; k < NGRP; k++) begin : g_sum
    logic [W-1:0] pk, gk;
    assign pk = {{(W-GRP_W){1'b0}}, s_p[k*GRP_W +: GRP_W]};
    assign gk = {{(W-GRP_W){1'b0}}, s_g[k*GRP_W +: GRP_W]};
    for (genvar j = 0; j < GRP_W; j++) begin : g_bit
      assign sum_w[k*GRP_W+j] = s_p[k*GRP_W+j] ^ carry_at(pk, gk, blk_c[k], j);
    end
  end

  assign out_valid = s_v;
  assign result    = s_idle ? s_pass : sum_w;
  assign carry_out = blk_c[NGRP];
  assign grp_p     = s_gp;
  assign grp_g     = s_gg;
endmodule

// File: rtl/lookahead_addsub_chk.sv
module lookahead_addsub_chk #(
  parameter int GRP_W = 4,
  parameter int NGRP  = 4,
  parameter bit PIPE  = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [GRP_W*NGRP-1:0]  a,
  input logic [GRP_W*NGRP-1:0]  b,
  input logic                   sub,
  input logic                   out_valid,
  input logic [GRP_W*NGRP-1:0]  result,
  input logic                   carry_out,
  input logic [NGRP-1:0]        grp_p,
  input logic [NGRP-1:0]        grp_g
);
  localparam int W = GRP_W * NGRP;

  logic [W-1:0] r_a, r_b;
  logic         r_sub;

  if (PIPE) begin : g_al
    always_ff @(posedge clk) begin
      r_a   <= a;
      r_b   <= b;
      r_sub <= sub;
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R7
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R7
    AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |-> !out_valid); // R8
  end else begin : g_al
    assign r_a   = a;
    assign r_b   = b;
    assign r_sub = sub;
  end

  logic [W:0] ref_sum;
  assign ref_sum = r_sub ? ({1'b0, r_a} + {1'b0, ~r_b} + (W+1)'(1))
                         : ({1'b0, r_a} + {1'b0, r_b});

  AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> result == ref_sum[W-1:0]); // R1
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && r_sub |-> carry_out == (r_a >= r_b)); // R2
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !r_sub |-> carry_out == ref_sum[W]); // R3
  AST_TAP_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (grp_p & grp_g) == '0); // R5
  AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !r_sub && (r_a == '0 || r_b == '0)
      |-> grp_p == '0 && grp_g == '0 && !carry_out); // R6
endmodule

bind lookahead_addsub lookahead_addsub_chk #(.GRP_W(GRP_W), .NGRP(NGRP), .PIPE(PIPE)) u_chk (.*);

// File: tb/sim_lookahead_addsub.sv
module sim_lookahead_addsub;
  localparam int GW = 4;
  localparam int NG = 2;
  localparam int W  = GW * NG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic sub = 1'b0;
  logic out_valid, carry_out;
  logic [W-1:0] result;
  logic [NG-1:0] grp_p, grp_g;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lookahead_addsub #(.GRP_W(GW), .NGRP(NG), .PIPE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .sub(sub),
    .out_valid(out_valid), .result(result), .carry_out(carry_out),
    .grp_p(grp_p), .grp_g(grp_g));

  logic          e_v = 1'b0, e_sub = 1'b0, e_gate = 1'b0, e_co = 1'b0;
  logic [W-1:0]  e_res = '0;
  logic [NG-1:0] e_gp = '0, e_gg = '0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check_out();
    check("R7", "out_valid", int'(out_valid), int'(e_v));
    if (e_v) begin
      check(e_sub ? "R2" : "R1", "result", int'(result), int'(e_res));
      check(e_sub ? "R2" : "R3", "carry_out", int'(carry_out), int'(e_co));
      check(e_gate ? "R6" : "R4", "grp_p", int'(grp_p), int'(e_gp));
      check(e_gate ? "R6" : "R4", "grp_g", int'(grp_g), int'(e_gg));
      check("R5", "overlap", int'(grp_p & grp_g), 0);
    end
  endtask

  task automatic issue(input logic v, input logic [W-1:0] x, input logic [W-1:0] y, input logic s);
    logic [W:0] full;
    logic [W-1:0] be;
    logic [GW-1:0] xs, ys;
    logic [GW:0] gs;
    in_valid = v; a = x; b = y; sub = s;
    be = s ? ~y : y;
    full = {1'b0, x} + {1'b0, be} + (W+1)'(s);
    e_v = v;
    e_sub = s;
    e_gate = !s && (x == '0 || y == '0);
    e_res = full[W-1:0];
    e_co = full[W];
    for (int k = 0; k < NG; k++) begin
      xs = x[k*GW +: GW];
      ys = be[k*GW +: GW];
      gs = {1'b0, xs} + {1'b0, ys};
      e_gp[k] = e_gate ? 1'b0 : ((xs ^ ys) == '1);
      e_gg[k] = e_gate ? 1'b0 : gs[GW];
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "out_valid after reset", int'(out_valid), 0);
    issue(1'b0, '0, '0, 1'b0);
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < (1 << W); x++) begin
        for (int y = 0; y < (1 << W); y++) begin
          @(negedge clk);
          check_out();
          if (y == 0 && (x % 32) == 0) begin
            issue(1'b0, W'(x), W'(y), m[0]);
            @(negedge clk);
            check_out();
          end
          issue(1'b1, W'(x), W'(y), m[0]);
        end
      end
    end
    @(negedge clk);
    check_out();
    issue(1'b0, '0, '0, 1'b0);
    @(negedge clk);
    check_out();
    finish_run();
  end
endmodule